// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a simple internal request bus, which addresses bytes, to an external 16-bit asynchronous static RAM holding 512K halfwords. It drives the memory address, chip enable, output enable, write enable and one strobe per byte lane. A separate data-out bus, with its own drive-enable, and a data-in bus stand in for the bidirectional pins. The block decodes a fixed 1 MB window of the host address space as the memory.

Every access that reaches the memory has two phases: an address-setup phase, then a data phase. The length of each phase is set in clock cycles by configuration inputs. Reads and writes can use separate phase lengths. Configuration inputs also gate writes and enable the whole memory. Byte accesses are steered onto the correct half of the 16-bit memory word. A request that is not carried out still finishes its handshake, so the host never stalls.

Top module: `sram_async_ctrl`

## Requirements
- R1: An access that reaches the memory holds `mem_ce_n` low for A setup clocks with `mem_oe_n` and `mem_we_n` high, then for D data clocks, where a data length of 0 counts as 1. `req_ready` rises in the clock that follows the data phase.
- R2: While `mem_ce_n` is low, `mem_addr` equals host address bits [19:1] and does not change.
- R3: `req_size` = 0 selects a byte access and 1 selects a halfword. An even byte asserts only `mem_lb_n`, an odd byte asserts only `mem_ub_n`, and a halfword asserts both. No lane strobe is asserted while the chip is deselected.
- R4: The chip is selected only when host address bits [31:20] equal 0x680. A request outside that window never selects the chip and gets `req_ready` in the clock after acceptance.
- R5: In a read, `mem_oe_n` is low for the whole data phase and only then. Data is captured on the last data clock. A halfword read returns the full word. A byte read returns the chosen lane in bits [7:0] with zeros above.
- R6: In a write, `mem_we_n` is low for the data phase only. `mem_dq_oe` is high through both phases. A byte write places data bits [7:0] on both halves of `mem_dq_out`.
- R7: With `cfg_ext_mode` = 1, writes use `cfg_wr_addset`/`cfg_wr_datast`. With `cfg_ext_mode` = 0, writes use the read settings.
- R8: With `cfg_wr_en` = 0, a write request never selects the chip and leaves the memory contents unchanged, but it still completes its handshake.
- R9: With `cfg_bank_en` = 0, no request of any kind selects the chip.
- R10: `req_ready` is a single-clock pulse. A request is accepted only when the block is idle. Timing settings are sampled at acceptance, so changing them during an access has no effect on that access.
- R11: After reset all memory strobes are high, `mem_dq_oe` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bank_en | input | 1 | Enables any external access |
| cfg_wr_en | input | 1 | Allows writes to reach the memory |
| cfg_ext_mode | input | 1 | Selects separate write timing |
| cfg_rd_addset | input | 4 | Read (and shared) setup clocks |
| cfg_rd_datast | input | 8 | Read (and shared) data clocks |
| cfg_wr_addset | input | 4 | Write setup clocks in separate-timing mode |
| cfg_wr_datast | input | 8 | Write data clocks in separate-timing mode |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `req_ready` |
| mem_addr | output | 19 | Memory halfword address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench exercises the following cases:
- Halfword writes and reads, then both byte lanes written one at a time and read back as a halfword and as single bytes. This separates correct lane steering from swapped or shared strobes.
- Phase lengths that include zero setup and zero data clocks. Writes issued with the separate-timing mode on and off. A timing change made in the middle of an access. These show whether phase counting, the zero-data rule and the point where timing is sampled are correct.
- Requests that must not reach the memory: outside the window, with writes gated off, and with the memory disabled. Each is followed by a read-back, which tells a request that was dropped properly apart from one that was performed or that hung.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int HADDR_W = 32,
  parameter int MADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int ASET_W = 4,
  parameter int DSET_W = 8,
  parameter logic [31:0] WIN_BASE = 32'h6800_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_bank_en,
  input  logic               cfg_wr_en,
  input  logic               cfg_ext_mode,
  input  logic [ASET_W-1:0]  cfg_rd_addset,
  input  logic [DSET_W-1:0]  cfg_rd_datast,
  input  logic [ASET_W-1:0]  cfg_wr_addset,
  input  logic [DSET_W-1:0]  cfg_wr_datast,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_size,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [MADDR_W-1:0] mem_addr,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic               mem_ub_n,
  output logic               mem_lb_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in
);

  localparam int LANE_W = DATA_W / 2;
  localparam int WIN_LSB = MADDR_W + 1;
  localparam int CNT_W = (ASET_W > DSET_W) ? ASET_W : DSET_W;
  localparam logic [HADDR_W-WIN_LSB-1:0] WIN_TAG = WIN_BASE[HADDR_W-1:WIN_LSB];

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DATA, ST_DONE} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    dlen_m1;
  logic                is_wr, is_byte, lane_hi;
  logic [MADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]   wdat_q;
  logic [DATA_W-1:0]   rdata_q;

  logic                use_wr_tim, in_win, perform;
  logic [ASET_W-1:0]   a_sel;
  logic [DSET_W-1:0]   d_sel;
  logic [CNT_W-1:0]    d_sel_m1;
  logic                active;

  assign use_wr_tim = req_write && cfg_ext_mode;
  assign a_sel      = use_wr_tim ? cfg_wr_addset : cfg_rd_addset;
  assign d_sel      = use_wr_tim ? cfg_wr_datast : cfg_rd_datast;
  assign d_sel_m1   = (d_sel == '0) ? '0 : CNT_W'(d_sel) - CNT_W'(1);
  assign in_win     = (req_addr[HADDR_W-1:WIN_LSB] == WIN_TAG);
  assign perform    = cfg_bank_en && in_win && (!req_write || cfg_wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      dlen_m1 <= '0;
      is_wr   <= 1'b0;
      is_byte <= 1'b0;
      lane_hi <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          is_wr   <= req_write;
          is_byte <= !req_size;
          lane_hi <= req_addr[0];
          addr_q  <= req_addr[MADDR_W:1];
          wdat_q  <= req_size ? req_wdata : {2{req_wdata[LANE_W-1:0]}};
          dlen_m1 <= d_sel_m1;
          if (!perform) begin
            state <= ST_DONE;
          end else if (a_sel != '0) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(a_sel) - CNT_W'(1);
          end else begin
            state <= ST_DATA;
            cnt   <= d_sel_m1;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_DATA;
            cnt   <= dlen_m1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            state <= ST_DONE;
            if (!is_wr) begin
              if (!is_byte)     rdata_q <= mem_dq_in;
              else if (lane_hi) rdata_q <= {{LANE_W{1'b0}}, mem_dq_in[DATA_W-1:LANE_W]};
              else              rdata_q <= {{LANE_W{1'b0}}, mem_dq_in[LANE_W-1:0]};
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active     = (state == ST_SETUP) || (state == ST_DATA);
  assign mem_ce_n   = !active;
  assign mem_oe_n   = !((state == ST_DATA) && !is_wr);
  assign mem_we_n   = !((state == ST_DATA) && is_wr);
  assign mem_lb_n   = !(active && (!is_byte || !lane_hi));
  assign mem_ub_n   = !(active && (!is_byte || lane_hi));
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign mem_dq_oe  = active && is_wr;
  assign req_ready  = (state == ST_DONE);
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int MADDR_W = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [MADDR_W-1:0] mem_addr,
  input logic               mem_ce_n,
  input logic               mem_oe_n,
  input logic               mem_we_n,
  input logic               mem_ub_n,
  input logic               mem_lb_n,
  input logic               mem_dq_oe
);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_ready_after_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n || mem_we_n);

  p_strobe_in_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);

  p_lane_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_ub_n && mem_lb_n));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_we_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_ub_n && mem_lb_n && !mem_dq_oe));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.MADDR_W(MADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bank_en = 0, cfg_wr_en = 0, cfg_ext_mode = 0;
  logic [3:0] cfg_rd_addset = 0, cfg_wr_addset = 0;
  logic [7:0] cfg_rd_datast = 0, cfg_wr_datast = 0;
  logic req_valid = 0, req_write = 0, req_size = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] pmem [256];
  logic [15:0] shadow [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en),
    .cfg_ext_mode(cfg_ext_mode), .cfg_rd_addset(cfg_rd_addset), .cfg_rd_datast(cfg_rd_datast),
    .cfg_wr_addset(cfg_wr_addset), .cfg_wr_datast(cfg_wr_datast), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always_comb mem_dq_in = (!mem_oe_n) ? pmem[mem_addr[7:0]] : 16'h0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model: state advanced at posedge, compared at negedge
  bit m_busy = 0, m_perf, m_wr, m_hw, m_hi;
  int m_k, m_a, m_d, m_total;
  logic [18:0] m_maddr;
  logic [15:0] m_wdat, m_exprd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_busy = 0;
    else if (m_busy) begin
      if (m_k == m_total) m_busy = 0; else m_k++;
    end else if (req_valid) begin
      int idx;
      m_busy = 1; m_k = 0;
      m_wr = req_write; m_hw = req_size; m_hi = req_addr[0];
      m_maddr = req_addr[19:1];
      idx = int'(req_addr[8:1]);
      m_wdat = req_size ? req_wdata : {req_wdata[7:0], req_wdata[7:0]};
      m_perf = cfg_bank_en && (req_addr[31:20] == 12'h680) && (!req_write || cfg_wr_en);
      m_a = (req_write && cfg_ext_mode) ? int'(cfg_wr_addset) : int'(cfg_rd_addset);
      m_d = (req_write && cfg_ext_mode) ? int'(cfg_wr_datast) : int'(cfg_rd_datast);
      if (m_d == 0) m_d = 1;
      m_total = m_perf ? m_a + m_d : 0;
      if (m_perf && m_wr) begin
        if (m_hw || !m_hi) shadow[idx][7:0] = m_wdat[7:0];
        if (m_hw || m_hi)  shadow[idx][15:8] = m_wdat[15:8];
      end
      m_exprd = m_hw ? shadow[idx] : (m_hi ? {8'h00, shadow[idx][15:8]} : {8'h00, shadow[idx][7:0]});
    end
  end

  always @(negedge clk) begin
    bit in_s, in_d, act, rdy;
    logic [1:0] lanes;
    cyc++;
    in_s = m_busy && m_perf && (m_k < m_a);
    in_d = m_busy && m_perf && (m_k >= m_a) && (m_k < m_a + m_d);
    act = in_s || in_d;
    rdy = m_busy && (m_k == m_total);
    lanes = !act ? 2'b11 : (m_hw ? 2'b00 : (m_hi ? 2'b01 : 2'b10));
    if (!mem_ce_n && !mem_we_n) begin
      if (!mem_lb_n) pmem[mem_addr[7:0]][7:0] = mem_dq_out[7:0];
      if (!mem_ub_n) pmem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
    chk(mem_ce_n == !act, "R1 chip enable", 32'(mem_ce_n), 32'(!act));
    chk(mem_oe_n == !(in_d && !m_wr), "R5 output enable", 32'(mem_oe_n), 32'(!(in_d && !m_wr)));
    chk(mem_we_n == !(in_d && m_wr), "R6 write enable", 32'(mem_we_n), 32'(!(in_d && m_wr)));
    chk(mem_dq_oe == (act && m_wr), "R6 drive enable", 32'(mem_dq_oe), 32'(act && m_wr));
    chk({mem_ub_n, mem_lb_n} == lanes, "R3 lane strobes", 32'({mem_ub_n, mem_lb_n}), 32'(lanes));
    chk(req_ready == rdy, "R10 ready", 32'(req_ready), 32'(rdy));
    if (act) chk(mem_addr == m_maddr, "R2 address", 32'(mem_addr), 32'(m_maddr));
    if (act && m_wr) chk(mem_dq_out == m_wdat, "R6 write data", 32'(mem_dq_out), 32'(m_wdat));
    if (rdy && m_perf && !m_wr) chk(rsp_rdata == m_exprd, "R5 model read", 32'(rsp_rdata), 32'(m_exprd));
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run(input string tag, input bit wr, input bit hw, input logic [31:0] a,
                     input logic [15:0] d, input int exp_ce, input bit chk_rd,
                     input logic [15:0] exp_rd, input bit mid_change);
    int ce_cnt = 0;
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = hw; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (mid_change && guard == 0) begin cfg_rd_addset = 4'd7; cfg_rd_datast = 8'd3; end
      guard++;
      if (!mem_ce_n) ce_cnt++;
      if (req_ready || guard > 1000) break;
    end
    req_valid = 0;
    chk(ce_cnt == exp_ce, tag, 32'(ce_cnt), 32'(exp_ce));
    if (chk_rd) chk(rsp_rdata == exp_rd, tag, 32'(rsp_rdata), 32'(exp_rd));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin pmem[i] = 16'h0; shadow[i] = 16'h0; end
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'b11111, "R11 strobes",
        32'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1f);
    chk(!mem_dq_oe && !req_ready, "R11 drive/ready", 32'({mem_dq_oe, req_ready}), 0);
    rst_n = 1;
    cfg_bank_en = 1; cfg_wr_en = 1; cfg_ext_mode = 0;
    cfg_rd_addset = 4'd2; cfg_rd_datast = 8'd3; cfg_wr_addset = 4'd1; cfg_wr_datast = 8'd1;
    // R7: shared timing when separate mode is off
    run("R7 shared write timing", 1, 1, 32'h6800_0010, 16'h1234, 5, 0, 0, 0);
    run("R5 halfword read", 0, 1, 32'h6800_0010, 0, 5, 1, 16'h1234, 0);
    // R3: lanes written separately
    run("R3 odd byte write", 1, 0, 32'h6800_0021, 16'h00AB, 5, 0, 0, 0);
    run("R3 even byte write", 1, 0, 32'h6800_0020, 16'h99CD, 5, 0, 0, 0);
    run("R3 merged halfword", 0, 1, 32'h6800_0020, 0, 5, 1, 16'hABCD, 0);
    run("R5 odd byte read", 0, 0, 32'h6800_0021, 0, 5, 1, 16'h00AB, 0);
    run("R5 even byte read", 0, 0, 32'h6800_0020, 0, 5, 1, 16'h00CD, 0);
    // R7: separate write timing
    cfg_ext_mode = 1;
    run("R7 separate write timing", 1, 1, 32'h6800_0030, 16'h5A5A, 2, 0, 0, 0);
    run("R7 read keeps read timing", 0, 1, 32'h6800_0030, 0, 5, 1, 16'h5A5A, 0);
    // R1: zero setup, zero data counts as one
    cfg_wr_addset = 4'd0; cfg_wr_datast = 8'd0;
    run("R1 zero-length phases", 1, 1, 32'h6800_0040, 16'h0F0F, 1, 0, 0, 0);
    run("R1 zero-length readback", 0, 1, 32'h6800_0040, 0, 5, 1, 16'h0F0F, 0);
    // R8: writes gated off
    cfg_wr_en = 0;
    run("R8 gated write", 1, 1, 32'h6800_0010, 16'hFFFF, 0, 0, 0, 0);
    run("R8 data unchanged", 0, 1, 32'h6800_0010, 0, 5, 1, 16'h1234, 0);
    cfg_wr_en = 1;
    // R4: outside the window
    run("R4 write above window", 1, 1, 32'h6810_0010, 16'hEEEE, 0, 0, 0, 0);
    run("R4 read below window", 0, 1, 32'h67FF_FFFE, 0, 0, 0, 0, 0);
    run("R4 data unchanged", 0, 1, 32'h6800_0010, 0, 5, 1, 16'h1234, 0);
    // R2: top of window
    run("R2 top address write", 1, 1, 32'h680F_FFFE, 16'h7766, 1, 0, 0, 0);
    run("R2 top address read", 0, 0, 32'h680F_FFFF, 0, 5, 1, 16'h0077, 0);
    // R9: memory disabled
    cfg_bank_en = 0;
    run("R9 disabled read", 0, 1, 32'h6800_0010, 0, 0, 0, 0, 0);
    run("R9 disabled write", 1, 1, 32'h6800_0010, 16'h4444, 0, 0, 0, 0);
    cfg_bank_en = 1;
    run("R9 data unchanged", 0, 1, 32'h6800_0010, 0, 5, 1, 16'h1234, 0);
    // R10: timing change during an access is not applied to it
    run("R10 mid-access change", 0, 1, 32'h6800_0030, 0, 5, 1, 16'h5A5A, 1);
    run("R1 new setup length", 0, 1, 32'h6800_0030, 0, 10, 1, 16'h5A5A, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule